// File: doc/BRIEF.md
# Command thread control register bank

This block is the control and status window of one thread of a command-queue engine. Software reaches it over a simple register bus. Each thread's window sits at base `0x100 + 0x80*THREAD_IDX`. A window covers 0x80 bytes, and accesses outside it are left to the neighbouring windows. From the stored fields the block drives one thread sequencer: a warm-reset request, the enable, a suspend request, a program-counter load strobe with its value, the end address and the priority. It takes back from the sequencer whether the thread has stopped, whether it is blocked on an event, its current program counter, and its done and error events.

Warm reset is a request that clears itself and can be watched from the bus. Suspend is a handshake: software writes the request, then polls a status bit until the sequencer reports that it has stopped. A thread that is disabled always reports as stopped. Any write to the current-address register, even with the value just read, makes the sequencer drop what it has prefetched and restart at the written address. Done and error events collect in a sticky interrupt status. The status is masked by an enable field into a single pending line.

Top module: `thr_ctrl_regbank`

## Requirements
- R1: An access hits only when `bus_addr[ADDR_W-1:7]` equals the window base shifted right by 7. A miss changes no state and raises no `bus_rvalid`.
- R2: A read hit raises `bus_rvalid` for one cycle on the next clock, with the register value in `bus_rdata`. Offsets with no register read 0.
- R3: Writing 1 to bit 0 at offset 0x00 raises `thr_rst_req` for exactly RST_CYCLES cycles, starting the cycle after the write. Bit 0 at 0x00 reads 1 while the request is high. The reset clears the enable, the suspend request and all interrupt status bits.
- R4: Bit 0 at offset 0x04 is the thread enable and drives `thr_enable`. It is 0 after reset.
- R5: Bit 0 at offset 0x08 drives `thr_suspend_req` (1 requests a suspend, 0 resumes). Status bit 1 at offset 0x0C reads 1 when `thr_suspended` is high or the thread is not enabled.
- R6: The interrupt status at offset 0x10 sets bit 0 on `thr_done_evt`, bit 1 on `thr_err_evt[0]` and bit 4 on `thr_err_evt[1]`. Writing 0 to a bit clears it and writing 1 leaves it unchanged. An event in the same cycle as a clearing write sets the bit.
- R7: The interrupt enable at offset 0x14 keeps only bits 0, 1 and 4, so an all-ones write reads back 0x13. `thr_irq` is high when any status bit and its enable bit are both 1.
- R8: A write to offset 0x20 pulses `thr_pc_load` for one cycle, on the cycle after the write, with the written value on `thr_pc_value`. A read of 0x20 returns `thr_cur_pc`.
- R9: Offset 0x24 stores the end address, driven on `thr_end_pc`. Offset 0x40 stores the low PRIO_W bits as the priority, driven on `thr_priority`. Both read back.
- R10: Bit 31 at offset 0x30 reads the value of `thr_waiting`. All other bits of that register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read hit |
| bus_rdata | output | 32 | Read data |
| thr_rst_req | output | 1 | Warm-reset request to the sequencer |
| thr_enable | output | 1 | Thread enable |
| thr_suspend_req | output | 1 | Suspend request |
| thr_pc_load | output | 1 | One-cycle program-counter load strobe |
| thr_pc_value | output | PC_W | Address to load |
| thr_end_pc | output | PC_W | End address |
| thr_priority | output | PRIO_W | Thread priority |
| thr_suspended | input | 1 | Sequencer has stopped |
| thr_waiting | input | 1 | Sequencer is blocked on an event |
| thr_cur_pc | input | PC_W | Sequencer's current program counter |
| thr_done_evt | input | 1 | Done event pulse |
| thr_err_evt | input | 2 | Error event pulses |
| thr_irq | output | 1 | Interrupt pending |

## Verification
The hardest case to reach from the ports is a done event landing in the same clock as a software write that clears the status bit. The bench builds that exact edge: from one falling edge it drives the clearing write together with the event, then reads back to confirm that the event won. The suspend handshake is also delicate, because the status answer comes from a small sequencer model in the bench that lags the request by one clock. Each status poll is therefore placed a cycle after that model settles. Warm-reset length is measured by counting falling edges while the request is high.

// File: rtl/thr_pkg.sv
package thr_pkg;

    localparam int unsigned WIN_BITS = 7;
    localparam int unsigned NSRC     = 3;
    localparam int unsigned IRQ_POS [NSRC] = '{0, 1, 4};

    localparam logic [6:0] OFS_WRST  = 7'h00;
    localparam logic [6:0] OFS_EN    = 7'h04;
    localparam logic [6:0] OFS_SUSP  = 7'h08;
    localparam logic [6:0] OFS_STAT  = 7'h0C;
    localparam logic [6:0] OFS_ISTAT = 7'h10;
    localparam logic [6:0] OFS_IEN   = 7'h14;
    localparam logic [6:0] OFS_CURPC = 7'h20;
    localparam logic [6:0] OFS_ENDPC = 7'h24;
    localparam logic [6:0] OFS_WAIT  = 7'h30;
    localparam logic [6:0] OFS_PRIO  = 7'h40;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_WRST,
        SEL_EN,
        SEL_SUSP,
        SEL_STAT,
        SEL_ISTAT,
        SEL_IEN,
        SEL_CURPC,
        SEL_ENDPC,
        SEL_WAIT,
        SEL_PRIO
    } sel_e;

    typedef struct packed {
        logic        valid;
        logic        write;
        sel_e        sel;
        logic [31:0] data;
    } bus_cmd_t;

    function automatic int unsigned window_base(input int unsigned idx);
        return 32'h100 + 32'h80 * idx;
    endfunction

    function automatic sel_e decode_offset(input logic [6:0] ofs);
        case (ofs)
            OFS_WRST:  return SEL_WRST;
            OFS_EN:    return SEL_EN;
            OFS_SUSP:  return SEL_SUSP;
            OFS_STAT:  return SEL_STAT;
            OFS_ISTAT: return SEL_ISTAT;
            OFS_IEN:   return SEL_IEN;
            OFS_CURPC: return SEL_CURPC;
            OFS_ENDPC: return SEL_ENDPC;
            OFS_WAIT:  return SEL_WAIT;
            OFS_PRIO:  return SEL_PRIO;
            default:   return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/thr_addr_decode.sv
module thr_addr_decode
    import thr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned THREAD_IDX = 0
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output bus_cmd_t          cmd
);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(window_base(THREAD_IDX));

    logic hit;

    always_comb begin
        hit       = (addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
        cmd.valid = valid & hit;
        cmd.write = write;
        cmd.sel   = hit ? decode_offset(addr[WIN_BITS-1:0]) : SEL_NONE;
        cmd.data  = wdata;
    end
endmodule

// File: rtl/thr_warm_reset.sv
module thr_warm_reset #(
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic active
);
    localparam int unsigned CNT_W = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (!active) begin
            if (start) begin
                active <= 1'b1;
                cnt_q  <= CNT_W'(RST_CYCLES - 1);
            end
        end else if (cnt_q == '0) begin
            active <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/thr_irq_unit.sv
module thr_irq_unit #(
    parameter int unsigned NSRC = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            st_wr,
    input  logic            en_wr,
    input  logic [NSRC-1:0] wbits,
    input  logic [NSRC-1:0] evt,
    output logic [NSRC-1:0] st,
    output logic [NSRC-1:0] en,
    output logic            irq
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                st[g] <= 1'b0;
            end else if (evt[g]) begin
                st[g] <= 1'b1;
            end else if (st_wr && !wbits[g]) begin
                st[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                en[g] <= 1'b0;
            end else if (en_wr) begin
                en[g] <= wbits[g];
            end
        end
    end

    assign irq = |(st & en);
endmodule

// File: rtl/thr_ctrl_regbank.sv
module thr_ctrl_regbank
    import thr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned THREAD_IDX = 2,
    parameter int unsigned PC_W       = 32,
    parameter int unsigned PRIO_W     = 3,
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_rvalid,
    output logic [31:0]       bus_rdata,
    output logic              thr_rst_req,
    output logic              thr_enable,
    output logic              thr_suspend_req,
    output logic              thr_pc_load,
    output logic [PC_W-1:0]   thr_pc_value,
    output logic [PC_W-1:0]   thr_end_pc,
    output logic [PRIO_W-1:0] thr_priority,
    input  logic              thr_suspended,
    input  logic              thr_waiting,
    input  logic [PC_W-1:0]   thr_cur_pc,
    input  logic              thr_done_evt,
    input  logic [1:0]        thr_err_evt,
    output logic              thr_irq
);
    bus_cmd_t cmd;
    logic wr, rd, wrst_start, hold_clr, rst_active;
    logic [NSRC-1:0] irq_wbits, irq_evt, irq_st, irq_en;
    logic [31:0] ist_word, ien_word, rd_mux;

    thr_addr_decode #(.ADDR_W(ADDR_W), .THREAD_IDX(THREAD_IDX)) u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cmd   (cmd)
    );

    assign wr = cmd.valid & cmd.write;
    assign rd = cmd.valid & ~cmd.write;
    assign wrst_start = wr && (cmd.sel == SEL_WRST) && cmd.data[0] && !rst_active;
    assign hold_clr = wrst_start | rst_active;

    thr_warm_reset #(.RST_CYCLES(RST_CYCLES)) u_wrst (
        .clk    (clk),
        .rst    (rst),
        .start  (wrst_start),
        .active (rst_active)
    );
    assign thr_rst_req = rst_active;

    assign irq_evt = {thr_err_evt[1], thr_err_evt[0], thr_done_evt};
    for (genvar g = 0; g < NSRC; g++) begin : g_wbits
        assign irq_wbits[g] = cmd.data[IRQ_POS[g]];
    end

    thr_irq_unit #(.NSRC(NSRC)) u_irq (
        .clk   (clk),
        .rst   (rst),
        .clr   (hold_clr),
        .st_wr (wr && (cmd.sel == SEL_ISTAT)),
        .en_wr (wr && (cmd.sel == SEL_IEN)),
        .wbits (irq_wbits),
        .evt   (rst_active ? '0 : irq_evt),
        .st    (irq_st),
        .en    (irq_en),
        .irq   (thr_irq)
    );

    always_comb begin
        ist_word = '0;
        ien_word = '0;
        for (int i = 0; i < NSRC; i++) begin
            ist_word[IRQ_POS[i]] = irq_st[i];
            ien_word[IRQ_POS[i]] = irq_en[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold_clr) begin
            thr_enable      <= 1'b0;
            thr_suspend_req <= 1'b0;
        end else if (wr) begin
            if (cmd.sel == SEL_EN)   thr_enable      <= cmd.data[0];
            if (cmd.sel == SEL_SUSP) thr_suspend_req <= cmd.data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_end_pc   <= '0;
            thr_priority <= '0;
            thr_pc_load  <= 1'b0;
            thr_pc_value <= '0;
        end else begin
            thr_pc_load <= wr && (cmd.sel == SEL_CURPC);
            if (wr && cmd.sel == SEL_CURPC) thr_pc_value <= cmd.data[PC_W-1:0];
            if (wr && cmd.sel == SEL_ENDPC) thr_end_pc   <= cmd.data[PC_W-1:0];
            if (wr && cmd.sel == SEL_PRIO)  thr_priority <= cmd.data[PRIO_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        case (cmd.sel)
            SEL_WRST:  rd_mux[0] = rst_active;
            SEL_EN:    rd_mux[0] = thr_enable;
            SEL_SUSP:  rd_mux[0] = thr_suspend_req;
            SEL_STAT:  rd_mux[1] = thr_suspended | ~thr_enable;
            SEL_ISTAT: rd_mux = ist_word;
            SEL_IEN:   rd_mux = ien_word;
            SEL_CURPC: rd_mux = 32'(thr_cur_pc);
            SEL_ENDPC: rd_mux = 32'(thr_end_pc);
            SEL_WAIT:  rd_mux[31] = thr_waiting;
            SEL_PRIO:  rd_mux = 32'(thr_priority);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= rd;
            if (rd) bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/thr_ctrl_regbank_chk.sv
module thr_ctrl_regbank_chk #(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned RST_CYCLES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rvalid,
    input logic              thr_rst_req,
    input logic              thr_enable,
    input logic              thr_suspend_req,
    input logic              thr_pc_load,
    input logic              thr_done_evt,
    input logic [1:0]        thr_err_evt,
    input logic              thr_irq
);
    logic [15:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst)              run_cnt <= '0;
        else if (thr_rst_req) run_cnt <= run_cnt + 1'b1;
        else                  run_cnt <= '0;
    end

    // R2
    a_r2_rvalid_after_read: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(bus_valid && !bus_write));

    // R3
    a_r3_reset_len: assert property (@(posedge clk) disable iff (rst)
        thr_rst_req |-> (run_cnt < 16'(RST_CYCLES)));

    // R3
    a_r3_reset_clears: assert property (@(posedge clk) disable iff (rst)
        thr_rst_req |-> (!thr_enable && !thr_suspend_req && !thr_irq));

    // R4
    a_r4_enable_by_write: assert property (@(posedge clk) disable iff (rst)
        $rose(thr_enable) |-> $past(bus_valid && bus_write && bus_wdata[0]));

    // R7
    a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(thr_irq) |-> $past(thr_done_evt || (|thr_err_evt) || (bus_valid && bus_write)));

    // R8
    a_r8_pc_load_src: assert property (@(posedge clk) disable iff (rst)
        thr_pc_load |-> $past(bus_valid && bus_write && bus_addr[6:0] == 7'h20));
endmodule

bind thr_ctrl_regbank thr_ctrl_regbank_chk #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_CYCLES)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .bus_valid       (bus_valid),
    .bus_write       (bus_write),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rvalid      (bus_rvalid),
    .thr_rst_req     (thr_rst_req),
    .thr_enable      (thr_enable),
    .thr_suspend_req (thr_suspend_req),
    .thr_pc_load     (thr_pc_load),
    .thr_done_evt    (thr_done_evt),
    .thr_err_evt     (thr_err_evt),
    .thr_irq         (thr_irq)
);

// File: tb/thr_ctrl_regbank_bench.sv
`timescale 1ns/1ps
module thr_ctrl_regbank_bench;
    localparam int unsigned ADDR_W = 16, PC_W = 32, PRIO_W = 3, RST_CYCLES = 4, TIDX = 2;
    localparam logic [15:0] BASE = 16'h0200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic bus_rvalid;
    logic [31:0] bus_rdata;
    logic thr_rst_req, thr_enable, thr_suspend_req, thr_pc_load, thr_irq;
    logic [PC_W-1:0] thr_pc_value, thr_end_pc;
    logic [PRIO_W-1:0] thr_priority;
    logic thr_suspended;
    logic thr_waiting = 1'b0;
    logic [PC_W-1:0] thr_cur_pc = '0;
    logic thr_done_evt = 1'b0;
    logic [1:0] thr_err_evt = 2'b00;

    int checks = 0, failures = 0, cyc = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    // sequencer model: stops one clock after a suspend request while enabled
    logic sus_m;
    always_ff @(posedge clk) begin
        if (rst) sus_m <= 1'b0;
        else     sus_m <= thr_suspend_req & thr_enable;
    end
    assign thr_suspended = sus_m;

    thr_ctrl_regbank #(.ADDR_W(ADDR_W), .THREAD_IDX(TIDX), .PC_W(PC_W),
                       .PRIO_W(PRIO_W), .RST_CYCLES(RST_CYCLES)) u_thr_ctrl_regbank (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .thr_rst_req(thr_rst_req), .thr_enable(thr_enable),
        .thr_suspend_req(thr_suspend_req), .thr_pc_load(thr_pc_load),
        .thr_pc_value(thr_pc_value), .thr_end_pc(thr_end_pc),
        .thr_priority(thr_priority), .thr_suspended(thr_suspended),
        .thr_waiting(thr_waiting), .thr_cur_pc(thr_cur_pc),
        .thr_done_evt(thr_done_evt), .thr_err_evt(thr_err_evt), .thr_irq(thr_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [31:0] d, output logic got);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        got = bus_rvalid;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
        logic [31:0] d;
        logic got;
        bus_rd(a, d, got);
        chk({req, " rvalid"}, 32'(got), 32'd1);
        chk(req, d, exp);
    endtask

    task automatic pulse_evt(input logic done, input logic [1:0] err);
        @(negedge clk);
        thr_done_evt = done; thr_err_evt = err;
        @(negedge clk);
        thr_done_evt = 1'b0; thr_err_evt = 2'b00;
    endtask

    task automatic t_reset_state();
        chk("R4 reset enable", 32'(thr_enable), 0);
        chk("R5 reset suspend", 32'(thr_suspend_req), 0);
        chk("R3 reset rst_req", 32'(thr_rst_req), 0);
        chk("R7 reset irq", 32'(thr_irq), 0);
        chk("R8 reset pc_load", 32'(thr_pc_load), 0);
        chk("R2 reset rvalid", 32'(bus_rvalid), 0);
    endtask

    task automatic t_window();
        logic [31:0] d;
        logic got;
        bus_wr(16'h0284, 32'h1);
        chk("R1 foreign write ignored", 32'(thr_enable), 0);
        bus_wr(16'h01FC, 32'h7);
        bus_wr(16'h0280 + 16'h40, 32'h7);
        bus_rd(16'h0284, d, got);
        chk("R1 foreign read no rvalid", 32'(got), 0);
        bus_rd(16'h01F4, d, got);
        chk("R1 below-window read no rvalid", 32'(got), 0);
        chk("R1 priority untouched", 32'(thr_priority), 0);
        rd_chk("R1 own window enable", BASE + 16'h04, 32'h0);
    endtask

    task automatic t_read_prio_end();
        rd_chk("R2 unmapped offset", BASE + 16'h18, 32'h0);
        bus_wr(BASE + 16'h40, 32'hFFFF_FFFF);
        chk("R9 priority out", 32'(thr_priority), 32'h7);
        rd_chk("R9 priority read", BASE + 16'h40, 32'h7);
        bus_wr(BASE + 16'h24, 32'hCAFE_0100);
        chk("R9 end out", thr_end_pc, 32'hCAFE_0100);
        rd_chk("R9 end read", BASE + 16'h24, 32'hCAFE_0100);
    endtask

    task automatic t_enable_suspend();
        rd_chk("R5 disabled counts suspended", BASE + 16'h0C, 32'h2);
        bus_wr(BASE + 16'h04, 32'h1);
        chk("R4 enable out", 32'(thr_enable), 1);
        rd_chk("R4 enable read", BASE + 16'h04, 32'h1);
        rd_chk("R5 running status", BASE + 16'h0C, 32'h0);
        bus_wr(BASE + 16'h08, 32'h1);
        chk("R5 suspend req out", 32'(thr_suspend_req), 1);
        @(negedge clk);
        rd_chk("R5 suspended status", BASE + 16'h0C, 32'h2);
        bus_wr(BASE + 16'h08, 32'h0);
        chk("R5 resume out", 32'(thr_suspend_req), 0);
        @(negedge clk);
        rd_chk("R5 resumed status", BASE + 16'h0C, 32'h0);
    endtask

    task automatic t_pc();
        bus_wr(BASE + 16'h20, 32'hABCD_0010);
        chk("R8 pc_load pulse", 32'(thr_pc_load), 1);
        chk("R8 pc value", thr_pc_value, 32'hABCD_0010);
        @(negedge clk);
        chk("R8 pc_load one cycle", 32'(thr_pc_load), 0);
        thr_cur_pc = 32'h1234_5678;
        rd_chk("R8 current pc read", BASE + 16'h20, 32'h1234_5678);
        bus_wr(BASE + 16'h20, 32'h1234_5678);
        chk("R8 same-value rewrite reloads", 32'(thr_pc_load), 1);
        chk("R8 same-value pc", thr_pc_value, 32'h1234_5678);
    endtask

    task automatic t_wait();
        thr_waiting = 1'b1;
        rd_chk("R10 waiting", BASE + 16'h30, 32'h8000_0000);
        thr_waiting = 1'b0;
        rd_chk("R10 not waiting", BASE + 16'h30, 32'h0);
    endtask

    task automatic t_irq();
        bus_wr(BASE + 16'h14, 32'hFFFF_FFFF);
        rd_chk("R7 enable mask", BASE + 16'h14, 32'h13);
        chk("R7 no irq yet", 32'(thr_irq), 0);
        pulse_evt(1'b0, 2'b01);
        rd_chk("R6 error a bit1", BASE + 16'h10, 32'h02);
        chk("R7 irq on error", 32'(thr_irq), 1);
        pulse_evt(1'b1, 2'b10);
        rd_chk("R6 done and error b", BASE + 16'h10, 32'h13);
        bus_wr(BASE + 16'h10, 32'hFFFF_FFEF);
        rd_chk("R6 clear bit4 only", BASE + 16'h10, 32'h03);
        bus_wr(BASE + 16'h10, 32'hFFFF_FFFD);
        rd_chk("R6 clear bit1 only", BASE + 16'h10, 32'h01);
        // clearing write and done event on the same edge
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = BASE + 16'h10; bus_wdata = 32'h0;
        thr_done_evt = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; thr_done_evt = 1'b0;
        rd_chk("R6 event beats clear", BASE + 16'h10, 32'h01);
        bus_wr(BASE + 16'h10, 32'h0);
        rd_chk("R6 cleared", BASE + 16'h10, 32'h00);
        chk("R7 irq drops", 32'(thr_irq), 0);
        bus_wr(BASE + 16'h14, 32'h1);
        pulse_evt(1'b0, 2'b01);
        rd_chk("R6 masked status still set", BASE + 16'h10, 32'h02);
        chk("R7 masked irq", 32'(thr_irq), 0);
        bus_wr(BASE + 16'h14, 32'h13);
        chk("R7 unmask raises irq", 32'(thr_irq), 1);
    endtask

    task automatic t_warm_reset();
        int n;
        bus_wr(BASE + 16'h04, 32'h1);
        bus_wr(BASE + 16'h08, 32'h1);
        bus_wr(BASE + 16'h00, 32'h1);
        chk("R3 request raised", 32'(thr_rst_req), 1);
        chk("R3 enable cleared", 32'(thr_enable), 0);
        chk("R3 suspend cleared", 32'(thr_suspend_req), 0);
        chk("R3 irq cleared", 32'(thr_irq), 0);
        n = 0;
        while (thr_rst_req && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk("R3 request length", 32'(n), 32'(RST_CYCLES));
        rd_chk("R3 bit self-clears", BASE + 16'h00, 32'h0);
        rd_chk("R3 status cleared", BASE + 16'h10, 32'h0);
        rd_chk("R3 enable reg cleared", BASE + 16'h04, 32'h0);
        bus_wr(BASE + 16'h00, 32'h1);
        rd_chk("R3 reads 1 while busy", BASE + 16'h00, 32'h1);
        repeat (RST_CYCLES + 1) @(negedge clk);
        chk("R3 finished", 32'(thr_rst_req), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_window();
        t_read_prio_end();
        t_enable_suspend();
        t_pc();
        t_wait();
        t_irq();
        t_warm_reset();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule